// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of asynchronous wakeup interrupt lines and a downstream interrupt controller that only recognises rising edges and active-high levels. Each channel holds a 3-bit trigger code and an enable bit, both set through a small memory-mapped register port. Each input line passes through a synchronizer. The block then detects the requested edge or level and drives one output per channel in a form the controller accepts.

Falling edges and active-low levels are turned around. In both-edge mode, a transition in either direction becomes a single rising-style pulse. When software rewrites a channel's trigger code, the edge history of that channel is reloaded at the same clock edge. A type change on a quiet line therefore never produces an event.

Top module: `wakeup_polarity_norm`

## Requirements
- R1: Enable bits live in 32-bit words at byte address 0x10 + 4*k. Channel n is bit n%32 of word n/32. All bits are 0 after reset. Bits for channels at or above NUM_CH, and words past the last implemented one, read 0 and ignore writes.
- R2: Channel n's trigger code is at byte address 0x110 + 4*n, in bits [2:0]. A read returns the stored code with bits [31:3] zero. Addresses for channels at or above NUM_CH read 0 and ignore writes. All codes are 000 after reset.
- R3: Each input passes through a two-flop synchronizer. A level change sampled at clock edge k shows at the output just after edge k+1.
- R4: Code 000 (active-low level): the output is high while the channel is enabled and the synchronized input is low.
- R5: Code 100 (active-high level): the output is high while the channel is enabled and the synchronized input is high.
- R6: Code 110 (rising edge): each rising transition gives exactly one single-cycle output pulse. Falling transitions give none.
- R7: Code 010 (falling edge): each falling transition gives exactly one single-cycle output pulse. Rising transitions give none.
- R8: Code 111 (both edges): each transition in either direction gives exactly one single-cycle output pulse.
- R9: Codes 001, 011 and 101 keep the output low whatever the input does.
- R10: A channel whose enable bit is 0 holds its output low.
- R11: A write to a channel's trigger code reloads that channel's edge history from the synchronizer. No edge pulse appears in the cycle after the write, even when the input changes at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_CH | Raw asynchronous wakeup lines |
| irq_out | output | NUM_CH | Normalized per-channel outputs |

## Verification
The bench builds the block with NUM_CH = 40 and ADDR_W = 12. This gives two enable words, and the second is only one quarter populated. The partly unused second word, the word past the end and the first configuration slot past the last channel can therefore all be reached with a few writes. Channel 33 confirms the word/bit split of the enable bank. The reload test lines up a trigger-code write with the clock edge at which a synchronized input rises. This is the case in which a design without history reload would emit a pulse.

// File: rtl/wpn_pkg.sv
package wpn_pkg;
   localparam int unsigned MAX_CH        = 168;
   localparam int unsigned REG_W         = 32;
   localparam int unsigned TRIG_W        = 3;
   localparam int unsigned EN_WORD_BASE  = 32'h10 / 4;
   localparam int unsigned CFG_WORD_BASE = 32'h110 / 4;

   typedef enum logic [TRIG_W-1:0] {
      TRIG_LVL_LO = 3'b000,
      TRIG_FALL   = 3'b010,
      TRIG_LVL_HI = 3'b100,
      TRIG_RISE   = 3'b110,
      TRIG_BOTH   = 3'b111
   } trig_e;
endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] next_o,
   output logic [WIDTH-1:0] dout_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din_i;
         for (int unsigned s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   // value the last stage takes on the next edge
   assign next_o = stage_q[STAGES-2];
   assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/wpn_regs.sv
module wpn_regs
   import wpn_pkg::*;
#(
   parameter int unsigned NUM_CH = 168,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wen_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [REG_W-1:0]              wdata_i,
   output logic [REG_W-1:0]              rdata_o,
   output logic [NUM_CH-1:0]             en_o,
   output logic [NUM_CH-1:0][TRIG_W-1:0] cfg_o,
   output logic [NUM_CH-1:0]             cfg_wr_o
);
   localparam int unsigned EN_WORDS = (NUM_CH + REG_W - 1) / REG_W;

   logic [31:0] word_addr;
   logic [31:0] en_idx;
   logic [31:0] cfg_idx;
   logic        en_hit;
   logic        cfg_hit;
   logic [NUM_CH-1:0]             en_q;
   logic [NUM_CH-1:0][TRIG_W-1:0] cfg_q;

   assign word_addr = 32'(addr_i[ADDR_W-1:2]);
   assign en_idx    = word_addr - EN_WORD_BASE;
   assign cfg_idx   = word_addr - CFG_WORD_BASE;
   assign en_hit    = (word_addr >= EN_WORD_BASE) && (word_addr < EN_WORD_BASE + EN_WORDS);
   assign cfg_hit   = (word_addr >= CFG_WORD_BASE) && (word_addr < CFG_WORD_BASE + NUM_CH);

   always_comb begin
      for (int unsigned c = 0; c < NUM_CH; c++)
         cfg_wr_o[c] = wen_i && cfg_hit && (cfg_idx == c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else begin
         for (int unsigned c = 0; c < NUM_CH; c++) begin
            if (wen_i && en_hit && (en_idx == c / REG_W)) en_q[c] <= wdata_i[c % REG_W];
            if (cfg_wr_o[c]) cfg_q[c] <= wdata_i[TRIG_W-1:0];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int unsigned c = 0; c < NUM_CH; c++) begin
         if (en_hit && (en_idx == c / REG_W)) rdata_o[c % REG_W] = en_q[c];
         if (cfg_hit && (cfg_idx == c)) rdata_o[TRIG_W-1:0] = cfg_q[c];
      end
   end

   assign en_o  = en_q;
   assign cfg_o = cfg_q;
endmodule

// File: rtl/wpn_chan.sv
module wpn_chan
   import wpn_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              sync_next_i,
   input  logic              en_i,
   input  logic [TRIG_W-1:0] cfg_i,
   input  logic              cfg_wr_i,
   output logic              irq_o
);
   logic hist_q;
   logic rise;
   logic fall;
   logic raw;

   // history is taken from the raw line, never the inverted one, so a
   // polarity change alone cannot look like a transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= 1'b0;
      else if (cfg_wr_i) hist_q <= sync_next_i;
      else               hist_q <= sync_i;
   end

   assign rise = sync_i & ~hist_q;
   assign fall = ~sync_i & hist_q;

   always_comb begin
      case (cfg_i)
         TRIG_LVL_LO: raw = ~sync_i;
         TRIG_LVL_HI: raw = sync_i;
         TRIG_RISE:   raw = rise;
         TRIG_FALL:   raw = fall;
         TRIG_BOTH:   raw = rise | fall;
         default:     raw = 1'b0;
      endcase
   end

   assign irq_o = en_i & raw;
endmodule

// File: rtl/wakeup_polarity_norm.sv
module wakeup_polarity_norm
   import wpn_pkg::*;
#(
   parameter int unsigned NUM_CH = 168,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] irq_in,
   output logic [NUM_CH-1:0] irq_out
);
   localparam int unsigned SYNC_STAGES = 2;
   localparam int unsigned WORD_SPAN   = 1 << (ADDR_W - 2);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_count
      $error("NUM_CH out of supported range");
   end
   if (ADDR_W > 32 || CFG_WORD_BASE + NUM_CH > WORD_SPAN) begin : g_bad_addr
      $error("ADDR_W too small for the configuration array");
   end

   logic [NUM_CH-1:0]             en_w;
   logic [NUM_CH-1:0][TRIG_W-1:0] cfg_w;
   logic [NUM_CH-1:0]             cfg_wr_w;
   logic [NUM_CH-1:0]             sync_w;
   logic [NUM_CH-1:0]             sync_nx_w;

   wpn_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen_i    (bus_wen),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .rdata_o  (bus_rdata),
      .en_o     (en_w),
      .cfg_o    (cfg_w),
      .cfg_wr_o (cfg_wr_w)
   );

   wpn_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (irq_in),
      .next_o (sync_nx_w),
      .dout_o (sync_w)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      wpn_chan u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .sync_i      (sync_w[g]),
         .sync_next_i (sync_nx_w[g]),
         .en_i        (en_w[g]),
         .cfg_i       (cfg_w[g]),
         .cfg_wr_i    (cfg_wr_w[g]),
         .irq_o       (irq_out[g])
      );
   end
endmodule

// File: rtl/wakeup_polarity_norm_chk.sv
module wakeup_polarity_norm_chk #(
   parameter int unsigned NUM_CH = 168
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH-1:0]       ch_en,
   input logic [NUM_CH-1:0][2:0]  ch_cfg,
   input logic [NUM_CH-1:0]       ch_cfg_wr,
   input logic [NUM_CH-1:0]       ch_sync,
   input logic [NUM_CH-1:0]       irq_out
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |-> !irq_out[i]);

      assert_unused_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_cfg[i] == 3'b001 || ch_cfg[i] == 3'b011 || ch_cfg[i] == 3'b101) |-> !irq_out[i]);

      assert_write_no_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
         ch_cfg_wr[i] |=> !(ch_cfg[i][1] && irq_out[i]));

      assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_cfg[i] == 3'b110 && irq_out[i]) |=> !(ch_cfg[i] == 3'b110 && irq_out[i]));

      assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_en[i] && ch_cfg[i] == 3'b100) |-> (irq_out[i] == ch_sync[i]));
   end
endmodule

bind wakeup_polarity_norm wakeup_polarity_norm_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_en     (en_w),
   .ch_cfg    (cfg_w),
   .ch_cfg_wr (cfg_wr_w),
   .ch_sync   (sync_w),
   .irq_out   (irq_out)
);

// File: tb/wakeup_polarity_norm_tb.sv
module wakeup_polarity_norm_tb;
   localparam int unsigned NCH = 40;
   localparam int unsigned AW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wen = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  irq_in = '0;
   logic [NCH-1:0]  irq_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] en0 = '0;

   always #5 clk = ~clk;

   wakeup_polarity_norm #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int unsigned addr, input logic [31:0] data);
      bus_addr = AW'(addr); bus_wdata = data; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input string tag, input int unsigned addr, input logic [31:0] exp);
      bus_addr = AW'(addr);
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   function automatic int unsigned cfg_a(input int unsigned ch);
      return 32'h110 + 4 * ch;
   endfunction

   task automatic set_en(input int unsigned ch, input logic v);
      en0[ch] = v;
      wr(32'h10, en0);
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulses(input int unsigned ch, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         if (irq_out[ch]) cnt++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rd("R1 enable word0 after reset", 32'h10, 0);
      rd("R1 enable word1 after reset", 32'h14, 0);
      rd("R2 cfg ch0 after reset", cfg_a(0), 0);
      chk("R10 outputs low after reset", 32'(irq_out), 0);
   endtask

   task automatic t_regmap();
      wr(32'h14, 32'hffff_ffff);
      rd("R1 partial word1 readback", 32'h14, 32'h0000_00ff);
      wr(32'h18, 32'hffff_ffff);
      rd("R1 word past end reads zero", 32'h18, 0);
      wr(cfg_a(5), 32'hffff_fffd);
      rd("R2 cfg ch5 keeps low 3 bits", cfg_a(5), 32'h5);
      wr(cfg_a(NCH), 32'h7);
      rd("R2 cfg past last channel", cfg_a(NCH), 0);
      wr(32'h14, 32'h2);
      wr(cfg_a(33), 32'h4);
      irq_in[33] = 1'b1; irq_in[32] = 1'b1;
      wait_n(3);
      chk("R1 ch33 enabled via word1 bit1", 32'(irq_out[33]), 1);
      chk("R1 ch32 left disabled", 32'(irq_out[32]), 0);
      wr(32'h14, 32'h0);
      irq_in[33] = 1'b0; irq_in[32] = 1'b0;
      wr(cfg_a(5), 32'h0);
   endtask

   task automatic t_level_low();
      wr(cfg_a(0), 32'h0); set_en(0, 1'b1);
      wait_n(3);
      chk("R4 active-low level, input low", 32'(irq_out[0]), 1);
      irq_in[0] = 1'b1; wait_n(3);
      chk("R4 active-low level, input high", 32'(irq_out[0]), 0);
   endtask

   task automatic t_latency();
      wr(cfg_a(1), 32'h4); set_en(1, 1'b1);
      irq_in[1] = 1'b1;
      @(negedge clk);
      chk("R3 one edge after drive still low", 32'(irq_out[1]), 0);
      @(negedge clk);
      chk("R3 two edges after drive high", 32'(irq_out[1]), 1);
      irq_in[1] = 1'b0; wait_n(3);
      chk("R5 level high follows low input", 32'(irq_out[1]), 0);
   endtask

   task automatic t_edge(input int unsigned ch, input logic [2:0] code,
                         input int exp_r, input int exp_f, input string tag);
      int c;
      wr(cfg_a(ch), 32'(code)); set_en(ch, 1'b1);
      irq_in[ch] = 1'b1; pulses(ch, 6, c);
      chk({tag, " pulses on rising input"}, 32'(c), 32'(exp_r));
      irq_in[ch] = 1'b0; pulses(ch, 6, c);
      chk({tag, " pulses on falling input"}, 32'(c), 32'(exp_f));
   endtask

   task automatic t_unused();
      int c;
      set_en(5, 1'b1);
      for (int k = 0; k < 3; k++) begin
         wr(cfg_a(5), 32'(2 * k + 1));
         irq_in[5] = 1'b1; pulses(5, 5, c);
         irq_in[5] = 1'b0; begin int c2; pulses(5, 5, c2); c += c2; end
         chk("R9 unused code stays silent", 32'(c), 0);
      end
   endtask

   task automatic t_disabled();
      wr(cfg_a(6), 32'h4);
      irq_in[6] = 1'b1; wait_n(3);
      chk("R10 disabled level-high channel", 32'(irq_out[6]), 0);
      set_en(6, 1'b1);
      chk("R10 enable exposes level", 32'(irq_out[6]), 1);
      set_en(6, 1'b0);
      chk("R10 disable clears output", 32'(irq_out[6]), 0);
   endtask

   task automatic t_phantom();
      int c;
      set_en(7, 1'b1);
      wr(cfg_a(7), 32'h4);
      irq_in[7] = 1'b1; wait_n(3);
      wr(cfg_a(7), 32'h6); pulses(7, 4, c);
      chk("R11 level-high to rising, stable high", 32'(c), 0);
      wr(cfg_a(7), 32'h2); pulses(7, 4, c);
      chk("R11 rising to falling, stable high", 32'(c), 0);
      wr(cfg_a(7), 32'h7); pulses(7, 4, c);
      chk("R11 falling to both, stable high", 32'(c), 0);
      irq_in[7] = 1'b0; wait_n(4);
      wr(cfg_a(7), 32'h2); pulses(7, 4, c);
      chk("R11 to falling, stable low", 32'(c), 0);
      wr(cfg_a(7), 32'h6); wait_n(2);
      irq_in[7] = 1'b1;
      @(negedge clk);
      wr(cfg_a(7), 32'h7);
      pulses(7, 4, c);
      chk("R11 write coincident with synced rise", 32'(c), 0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_level_low();
      t_latency();
      t_edge(2, 3'b110, 1, 0, "R6 rising");
      t_edge(3, 3'b010, 0, 1, "R7 falling");
      t_edge(4, 3'b111, 1, 1, "R8 both edges");
      t_unused();
      t_disabled();
      t_phantom();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule